// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block measures one external digital input. A 16-bit up-counter advances on a count-clock enable. Each valid edge of the input copies the current count into a period register and restarts the counter from zero. Each edge of the opposite polarity copies the count into a width register and leaves the counter running. The period and the active-level width therefore come straight out of the two registers, and software does not have to subtract anything.

A sticky overflow flag records each wrap of the counter past FFFFH. Software clears it by writing 0. When the flag is set, software adds 10000H for every overflow to the captured value. A one-cycle interrupt pulse accompanies each register load.

Software drives a small control write port, which sets the operating mode, picks the valid edge and clears the flag. A read port with a 2-bit address returns the control word, the live count and the two captured values.

Top module: `pwcap_timer`

## Requirements
- R1: After reset, every readable location reads 0 and both interrupt outputs are low.
- R2: Only mode value 2'b10 (control bits [1:0]) runs the measurement. In any other mode the count is held at 0, no capture occurs and no interrupt is raised.
- R3: In the running mode the count increments by one on each clock where `cnt_en` is high, and holds otherwise. It wraps from FFFFH to 0000H.
- R4: Control bit 2 selects the valid edge: 1 selects rising and 0 selects falling. A valid edge loads the pre-edge count into the period register (read address 2) and clears the count, whether or not `cnt_en` is high. This happens on the third rising clock edge after `sig_in` changes.
- R5: An edge of the opposite polarity loads the count into the width register (read address 3) at the same latency and does not clear the count.
- R6: The overflow flag (control bit 3, read address 0) is set when the count wraps. A control write with bit 3 at 0 clears it. A write with bit 3 at 1 leaves it unchanged.
- R7: If a valid edge clears the counter in the same cycle that it would wrap, the overflow flag is not set.
- R8: If a clearing write and a wrap happen in the same cycle, the flag ends up set.
- R9: `irq_period` and `irq_width` are single-cycle pulses. Each is high in the cycle its register holds the newly loaded value.
- R10: Each transition of `sig_in`, held for at least two clocks, produces exactly one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable |
| sig_in | input | 1 | Asynchronous input being measured |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 4 | Control write data: [1:0] mode, [2] rising-valid, [3] flag (write 0 to clear) |
| rd_addr | input | 2 | Read select: 0 control, 1 count, 2 period, 3 width |
| rd_data | output | 16 | Read data for `rd_addr` |
| irq_period | output | 1 | Pulse on period register load |
| irq_width | output | 1 | Pulse on width register load |

## Verification
A wrong count shows up on read address 1 in the cycle after the error. It also corrupts the next captured value, so it shows at the period or width register one capture later. Synchronizer or edge-detection faults move the interrupt pulses away from the expected third clock after an input change, or add or drop pulses, and that is visible within a few cycles. Overflow faults can only be reached at a wrap. The bench therefore drives the counter through two full wraps and lines a valid edge and a clearing write up exactly with the wrap.

// File: rtl/pwcap_timer.sv
module pwcap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         sig_in,
  input  logic         ctrl_wr,
  input  logic [3:0]   ctrl_wdata,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq_period,
  output logic         irq_width
);
  localparam logic [1:0] RUN_MODE = 2'b10;

  logic [2:0]   sync;
  logic [1:0]   mode;
  logic         rise_sel, ovf;
  logic [W-1:0] cnt, per_q, wid_q;

  wire run    = (mode == RUN_MODE);
  wire rise   = sync[1] & ~sync[2];
  wire fall   = ~sync[1] & sync[2];
  wire vld    = run & (rise_sel ? rise : fall);
  wire opp    = run & (rise_sel ? fall : rise);
  wire wrap   = run & cnt_en & (&cnt) & ~vld;
  wire clr_wr = ctrl_wr & ~ctrl_wdata[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], sig_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= '0;
      rise_sel <= 1'b0;
    end else if (ctrl_wr) begin
      mode     <= ctrl_wdata[1:0];
      rise_sel <= ctrl_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || vld) cnt <= '0;
    else if (cnt_en)      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q      <= '0;
      wid_q      <= '0;
      irq_period <= 1'b0;
      irq_width  <= 1'b0;
    end else begin
      if (vld) per_q <= cnt;
      if (opp) wid_q <= cnt;
      irq_period <= vld;
      irq_width  <= opp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf <= 1'b0;
    else if (wrap)   ovf <= 1'b1;
    else if (clr_wr) ovf <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {{(W-4){1'b0}}, ovf, rise_sel, mode};
      2'd1:    rd_data = cnt;
      2'd2:    rd_data = per_q;
      default: rd_data = wid_q;
    endcase
  end
endmodule

module pwcap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         ctrl_wr,
  input logic [3:0]   ctrl_wdata,
  input logic [1:0]   mode,
  input logic         ovf,
  input logic [W-1:0] cnt,
  input logic         rise,
  input logic         fall,
  input logic         irq_period,
  input logic         irq_width
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |=> (cnt == '0));

  a_r3_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !cnt_en && !rise && !fall) |=> $stable(cnt));

  a_r4_clear_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |-> (cnt == '0));

  a_r6_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(ctrl_wr && !ctrl_wdata[3])) |=> ovf);

  a_r9_period_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |=> !irq_period);

  a_r9_width_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_width |=> !irq_width);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_period && irq_width));
endmodule

bind pwcap_timer pwcap_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ctrl_wr(ctrl_wr),
  .ctrl_wdata(ctrl_wdata), .mode(mode), .ovf(ovf), .cnt(cnt),
  .rise(rise), .fall(fall), .irq_period(irq_period), .irq_width(irq_width)
);

// File: tb/pwcap_timer_test.sv
module pwcap_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        sig_in = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [3:0]  ctrl_wdata = 4'h0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic        irq_period, irq_width;

  int tests = 0, fails = 0, cycles = 0;
  int en_pat = 0;
  logic [7:0] lfsr = 8'h5a;
  int seen_p = 0, seen_w = 0;

  always #2.5 clk = ~clk;

  pwcap_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sig_in(sig_in),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_period(irq_period), .irq_width(irq_width)
  );

  // behavioural reference
  bit m_s1, m_s2, m_s3, m_esel, m_ovf, m_irqp, m_irqw;
  int m_mode, m_cnt, m_per, m_wid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_esel = 0; m_ovf = 0;
      m_irqp = 0; m_irqw = 0; m_mode = 0; m_cnt = 0; m_per = 0; m_wid = 0;
    end else begin
      bit r, f, run, v, o, wr;
      r = m_s2 && !m_s3;
      f = !m_s2 && m_s3;
      run = (m_mode == 2);
      v = run && (m_esel ? r : f);
      o = run && (m_esel ? f : r);
      wr = run && cnt_en && (m_cnt == 65535) && !v;
      m_irqp = v;
      m_irqw = o;
      if (v) m_per = m_cnt;
      if (o) m_wid = m_cnt;
      if (!run || v) m_cnt = 0;
      else if (cnt_en) m_cnt = (m_cnt + 1) % 65536;
      if (wr) m_ovf = 1;
      else if (ctrl_wr && !ctrl_wdata[3]) m_ovf = 0;
      if (ctrl_wr) begin
        m_mode = ctrl_wdata[1:0];
        m_esel = ctrl_wdata[2];
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig_in;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      int exp;
      string tag;
      case (rd_addr)
        2'd0: begin exp = (int'(m_ovf) << 3) | (int'(m_esel) << 2) | m_mode; tag = "R6 control word"; end
        2'd1: begin exp = m_cnt; tag = "R3 count"; end
        2'd2: begin exp = m_per; tag = "R4 period"; end
        default: begin exp = m_wid; tag = "R5 width"; end
      endcase
      chk(int'(rd_data) == exp, tag, rd_data, exp);
      chk(irq_period == m_irqp, "R9 irq_period", irq_period, m_irqp);
      chk(irq_width == m_irqw, "R9 irq_width", irq_width, m_irqw);
      if (irq_period) seen_p++;
      if (irq_width) seen_w++;
    end
  end

  task automatic step();
    @(negedge clk);
    ctrl_wr = 1'b0;
    rd_addr = rd_addr + 2'd1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (en_pat)
      0: cnt_en = 1'b1;
      1: cnt_en = ~cnt_en;
      default: cnt_en = lfsr[0];
    endcase
  endtask

  task automatic wr_ctrl(input logic [3:0] d);
    step();
    ctrl_wr = 1'b1;
    ctrl_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(input int hi, input int lo);
    step(); sig_in = ~sig_in; idle(hi);
    step(); sig_in = ~sig_in; idle(lo);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    ctrl_wr = 1'b0;
    rd_addr = a;
    #1 v = rd_data;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1 chk(rd_data == 16'h0, "R1 reset read", rd_data, 0);
    end
    chk(!irq_period && !irq_width, "R1 reset irq", {irq_period, irq_width}, 0);
    @(negedge clk) rst_n = 1'b1;

    // R2 R4 R5 R10: rising valid, several enable patterns
    wr_ctrl(4'h6);
    seen_p = 0; seen_w = 0;
    for (int p = 0; p < 3; p++) begin
      en_pat = p;
      pulse(5 + 3 * p, 9 + p);
      pulse(2, 2);
      pulse(20, 4);
    end
    idle(4);
    chk(seen_p == 9, "R10 period captures", seen_p, 9);
    chk(seen_w == 9, "R10 width captures", seen_w, 9);

    // falling valid (R4 R5)
    en_pat = 0;
    wr_ctrl(4'h2);
    pulse(7, 12);
    pulse(3, 30);
    idle(4);
    rd(2'd3, v);
    chk(v == m_wid, "R5 width falling-valid", v, m_wid);

    // other modes: no capture, count held (R2)
    seen_p = 0; seen_w = 0;
    wr_ctrl(4'h0);
    pulse(6, 6);
    wr_ctrl(4'h1);
    pulse(6, 6);
    wr_ctrl(4'h3);
    pulse(6, 6);
    idle(4);
    chk(seen_p == 0 && seen_w == 0, "R2 no capture when idle", seen_p + seen_w, 0);
    rd(2'd1, v);
    chk(v == 0, "R2 count held", v, 0);

    // wrap with simultaneous clearing write (R6 R8)
    wr_ctrl(4'h6);
    en_pat = 0;
    do step(); while (m_cnt != 65535);
    ctrl_wr = 1'b1; ctrl_wdata = 4'h6;
    idle(1);
    rd(2'd0, v);
    chk(v[3] == 1'b1, "R8 flag set despite clear", v, 32'hE);
    wr_ctrl(4'hE);
    idle(1);
    rd(2'd0, v);
    chk(v[3] == 1'b1, "R6 write one keeps flag", v, 32'hE);
    wr_ctrl(4'h6);
    idle(1);
    rd(2'd0, v);
    chk(v[3] == 1'b0, "R6 write zero clears flag", v, 32'h6);

    // valid edge coincides with wrap (R7)
    do step(); while (m_cnt != 65533);
    sig_in = 1'b1;
    idle(5);
    rd(2'd0, v);
    chk(v[3] == 1'b0, "R7 no flag on clear+wrap", v, 32'h6);
    rd(2'd2, v);
    chk(v == 16'hFFFF, "R7 period captured", v, 16'hFFFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end
endmodule